// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a level interrupt toward the CPU after a programmed number of video scanlines has passed. The video timing logic presents one tick per scanline together with the scanline number and a flag that says whether rendering is on. The block counts only visible lines while rendering and while it is armed. The CPU programs it through four write-only registers, selected by address.

When the count expires, the block reloads its counter from a latch and asserts the interrupt. It then freezes until the CPU writes any of its registers again. Scanline 0 takes an extra decrement of a nonzero count before the expiry test. Every counted tick ends with one more decrement, and that includes the tick that has just reloaded the counter.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt output is low and the counter, latch, arm bit and freeze flag are all zero. Arming the block and sending one counted tick on line 1 therefore asserts the interrupt at once.
- R2: A write is decoded on `wr_addr & 16'hE001`. 16'hC000 loads the counter from `wr_data`. 16'hC001 loads the latch. 16'hE000 clears the arm bit and drops the interrupt. 16'hE001 sets the arm bit. A write to any other address changes nothing.
- R3: Each of the four decoded writes clears the freeze flag.
- R4: A tick is counted only when all of these hold: `line_num` is at most 239, `render_on` is high, the arm bit is set and the freeze flag is clear. Any other tick changes nothing.
- R5: On a counted tick with `line_num` equal to 0, a nonzero counter is first decremented by one.
- R6: After the step in R5, if the counter is zero, the freeze flag is set, the counter is reloaded from the latch and the interrupt is asserted.
- R7: Every counted tick ends by decrementing the counter by one, modulo 256. This includes the tick that reloaded it, so a zero latch gives 255.
- R8: Once asserted, the interrupt stays high until a 16'hE000-class write or a reset.
- R9: When a decoded write and a tick arrive in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Scanline number carried with the tick |
| render_on | input | 1 | Rendering enabled |
| irq_out | output | 1 | Level interrupt request |

## Verification
The two functions that can meet in one cycle are the register write port and the scanline tick. The worst case is a disarm write landing on the same tick that would expire the count. The bench provokes this by driving `line_tick` in the same cycle as each of the four register classes and as a write to an unmapped address. A reference model in the bench lets the write win. The result is judged on the interrupt line and on how many later ticks it takes to reach the next expiry.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int CNT_W    = 8;
  localparam int LINE_W   = 9;
  localparam int ADDR_W   = 16;
  localparam int LAST_VIS = 239;

  typedef enum logic [2:0] {
    WC_NONE,
    WC_COUNT,
    WC_LATCH,
    WC_DISARM,
    WC_ARM
  } wr_class_e;

  typedef struct packed {
    logic [CNT_W-1:0] next_cnt;
    logic             expire;
  } step_t;

  function automatic wr_class_e classify(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = a & 16'hE001;
    case (m)
      16'hC000: classify = WC_COUNT;
      16'hC001: classify = WC_LATCH;
      16'hE000: classify = WC_DISARM;
      16'hE001: classify = WC_ARM;
      default:  classify = WC_NONE;
    endcase
  endfunction

  // One counted tick: optional pre-decrement on the first line, expiry test, then post-decrement.
  function automatic step_t count_step(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] lat,
                                       input logic             first_line);
    logic [CNT_W-1:0] mid;
    step_t r;
    mid = (first_line && cnt != '0) ? cnt - 1'b1 : cnt;
    r.expire = (mid == '0);
    if (r.expire) mid = lat;
    r.next_cnt = mid - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ld_count,
  output logic              ld_latch,
  output logic              disarm,
  output logic              arm,
  output logic              any_wr
);
  wr_class_e cls;
  always_comb begin
    cls      = wr_en ? classify(wr_addr) : WC_NONE;
    ld_count = (cls == WC_COUNT);
    ld_latch = (cls == WC_LATCH);
    disarm   = (cls == WC_DISARM);
    arm      = (cls == WC_ARM);
    any_wr   = (cls != WC_NONE);
  end
endmodule

// File: rtl/irq_tick_qual.sv
module irq_tick_qual
  import scanline_irq_pkg::*;
#(
  parameter int LW   = LINE_W,
  parameter int LAST = LAST_VIS
) (
  input  logic          line_tick,
  input  logic [LW-1:0] line_num,
  input  logic          render_on,
  input  logic          armed,
  input  logic          frozen,
  input  logic          any_wr,
  output logic          count_evt,
  output logic          first_line
);
  localparam logic [LW-1:0] LAST_L = LW'(LAST);
  always_comb begin
    count_evt  = line_tick && (line_num <= LAST_L) && render_on &&
                 armed && !frozen && !any_wr;
    first_line = (line_num == '0);
  end
endmodule

// File: rtl/irq_count_core.sv
module irq_count_core
  import scanline_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ld_count,
  input  logic             ld_latch,
  input  logic             disarm,
  input  logic             arm,
  input  logic             any_wr,
  input  logic             count_evt,
  input  logic             first_line,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             frozen_q,
  output logic             irq_q,
  output logic             expire_evt
);
  logic [CNT_W-1:0] lat_q;
  step_t            st;

  always_comb begin
    st         = count_step(cnt_q, lat_q, first_line);
    expire_evt = count_evt && st.expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lat_q    <= '0;
      armed_q  <= 1'b0;
      frozen_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (any_wr) begin
      frozen_q <= 1'b0;
      if (ld_count) cnt_q   <= wr_data;
      if (ld_latch) lat_q   <= wr_data;
      if (arm)      armed_q <= 1'b1;
      if (disarm) begin
        armed_q <= 1'b0;
        irq_q   <= 1'b0;
      end
    end else if (count_evt) begin
      cnt_q <= st.next_cnt;
      if (st.expire) begin
        frozen_q <= 1'b1;
        irq_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq_out
);
  logic ld_count, ld_latch, disarm, arm, any_wr;
  logic count_evt, first_line, expire_evt;
  logic armed_q, frozen_q;
  logic [CNT_W-1:0] cnt_q;

  irq_wr_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .ld_count(ld_count), .ld_latch(ld_latch),
    .disarm(disarm), .arm(arm), .any_wr(any_wr)
  );

  irq_tick_qual #(.LW(LINE_W), .LAST(LAST_VIS)) u_qual (
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on),
    .armed(armed_q), .frozen(frozen_q), .any_wr(any_wr),
    .count_evt(count_evt), .first_line(first_line)
  );

  irq_count_core u_core (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .ld_count(ld_count),
    .ld_latch(ld_latch), .disarm(disarm), .arm(arm), .any_wr(any_wr),
    .count_evt(count_evt), .first_line(first_line), .cnt_q(cnt_q),
    .armed_q(armed_q), .frozen_q(frozen_q), .irq_q(irq_out),
    .expire_evt(expire_evt)
  );
endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker
  import scanline_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             disarm,
  input logic             any_wr,
  input logic             line_tick,
  input logic             count_evt,
  input logic             expire_evt,
  input logic             frozen_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !disarm |=> irq_out);
  // R2
  disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !irq_out);
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out && !disarm && expire_evt |=> irq_out && frozen_q);
  // R4
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q && !any_wr |=> $stable(cnt_q) && frozen_q);
  // R3
  unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !frozen_q);
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr && line_tick |-> !count_evt);
endmodule

bind scanline_irq_counter scanline_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .disarm(disarm), .any_wr(any_wr),
  .line_tick(line_tick), .count_evt(count_evt), .expire_evt(expire_evt),
  .frozen_q(frozen_q), .cnt_q(cnt_q)
);

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, line_tick = 1'b0, render_on = 1'b1;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [8:0]  line_num = '0;
  logic irq_out;
  int checks = 0, errors = 0;
  int m_cnt = 0, m_lat = 0, m_irq = 0, m_arm = 0, m_frz = 0;

  always #5 clk = ~clk;

  scanline_irq_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on), .irq_out(irq_out)
  );

  task automatic check(input string req, input int exp_v);
    checks++;
    if (int'(irq_out) != exp_v) begin
      errors++;
      $display("FAIL %s irq_out actual %0d expected %0d at %0t", req, irq_out, exp_v, $time);
    end
  endtask

  // Reference: write decode by mask, else tick arithmetic done with integers.
  task automatic model(input bit we, input int a, input int d, input bit tk, input int ln, input bit rn);
    int k, c;
    k = we ? (a & 'hE001) : -1;
    if (k == 'hC000 || k == 'hC001 || k == 'hE000 || k == 'hE001) begin
      m_frz = 0;
      if (k == 'hC000) m_cnt = d;
      if (k == 'hC001) m_lat = d;
      if (k == 'hE000) begin m_arm = 0; m_irq = 0; end
      if (k == 'hE001) m_arm = 1;
    end else if (tk && ln < 240 && rn && m_arm && !m_frz) begin
      c = m_cnt;
      if (ln == 0 && c > 0) c = c - 1;
      if (c == 0) begin m_frz = 1; m_irq = 1; c = m_lat; end
      m_cnt = (c + 255) % 256;
    end
  endtask

  task automatic step(input string req, input bit we, input int a, input int d,
                      input bit tk, input int ln, input bit rn);
    @(negedge clk);
    wr_en = we; wr_addr = 16'(a); wr_data = 8'(d);
    line_tick = tk; line_num = 9'(ln); render_on = rn;
    @(posedge clk);
    #1;
    model(we, a, d, tk, ln, rn);
    wr_en = 1'b0; line_tick = 1'b0;
    check(req, m_irq);
  endtask

  task automatic wr(input string req, input int a, input int d);
    step(req, 1'b1, a, d, 1'b0, 0, 1'b1);
  endtask

  task automatic tick(input string req, input int ln, input bit rn);
    step(req, 1'b0, 0, 0, 1'b1, ln, rn);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", 0);
    wr("R1", 'hE001, 0);
    tick("R1", 1, 1'b1);
    wr("R8", 'hE000, 0);

    // R7 R6: counter sweep, no first-line ticks
    for (int n = 0; n < 24; n++) begin
      wr("R2", 'hC001, n + 3);
      wr("R2", 'hC000, n);
      wr("R2", 'hE001, 0);
      for (int t = 0; t < n + 3; t++) tick("R7", 1 + t, 1'b1);
      wr("R8", 'hE000, 0);
    end

    // R5: first-line pre-decrement sweep
    for (int n = 0; n < 12; n++) begin
      wr("R2", 'hC000, n);
      wr("R2", 'hE001, 0);
      tick("R5", 0, 1'b1);
      for (int t = 0; t < n + 2; t++) tick("R5", t % 2 == 0 ? 0 : 7, 1'b1);
      wr("R8", 'hE000, 0);
    end

    // R4: rejected ticks; line 240+, render off, disarmed
    wr("R4", 'hC000, 0);
    for (int l = 240; l < 262; l++) tick("R4", l, 1'b1);
    wr("R4", 'hE001, 0);
    for (int l = 240; l < 262; l++) tick("R4", l, 1'b1);
    for (int l = 0; l < 20; l++) tick("R4", l * 11, 1'b0);
    tick("R4", 239, 1'b1);
    // R6 R4: frozen after expiry
    for (int t = 0; t < 10; t++) tick("R6", t, 1'b1);
    // R8: holds across unmapped writes
    wr("R8", 'h8000, 0);
    wr("R8", 'hA001, 0);
    wr("R8", 'hE000, 0);

    // R7: zero latch reloads to 255
    wr("R7", 'hC001, 0);
    wr("R7", 'hC000, 0);
    wr("R7", 'hE001, 0);
    tick("R7", 0, 1'b1);
    wr("R3", 'hE000, 0);
    wr("R3", 'hE001, 0);
    for (int t = 0; t < 258; t++) tick("R7", 1 + (t % 200), 1'b1);
    wr("R8", 'hE000, 0);

    // R2: mask aliases
    wr("R2", 'hDFFE, 2);
    wr("R2", 'hFFFF, 0);
    for (int t = 0; t < 4; t++) tick("R2", 5, 1'b1);
    wr("R2", 'hC003, 9);
    wr("R2", 'hFFFE, 0);

    // R9 R3: collisions of each write class with a tick
    for (int c = 0; c < 5; c++) begin
      int addrs[5] = '{'hC000, 'hC001, 'hE001, 'hE000, 'h9000};
      wr("R9", 'hC001, 4);
      wr("R9", 'hC000, 0);
      wr("R9", 'hE001, 0);
      tick("R9", 3, 1'b1);
      step("R9", 1'b1, addrs[c], 1, 1'b1, 4, 1'b1);
      wr("R3", 'hE001, 0);
      for (int t = 0; t < 7; t++) tick("R9", 10 + t, 1'b1);
      wr("R9", 'hE000, 0);
    end
    wr("R9", 'hC000, 0);
    wr("R9", 'hE001, 0);
    step("R9", 1'b1, 'hE000, 0, 1'b1, 2, 1'b1);
    tick("R9", 3, 1'b1);

    // R1: reset mid-operation
    wr("R1", 'hE001, 0);
    tick("R1", 1, 1'b1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_cnt = 0; m_lat = 0; m_irq = 0; m_arm = 0; m_frz = 0;
    #1 check("R1", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule